// File: doc/BRIEF.md
# Stack Access Address Generator

This block turns a stack operation into the memory requests it needs and the stack-pointer value that results. A caller gives the current stack pointer, an operation (single push, single pop, eight-register bulk push or eight-register bulk pop), the operand size and the stack size, and pulses `start`. The block then issues one request per accepted cycle on a valid/ready port. Each request carries a kind (probe, load or store), an address, the operand size as its data size, the stack size as its address size, and, for bulk transfers, the index of the register involved. After the last request is accepted, the new stack pointer is reported for one cycle.

The rule behind the block is that two sizes play separate roles. The stack size sets the address size of every request and the width of the stack-pointer arithmetic. The operand size sets how far the pointer moves for each item. Bits of the pointer above the stack width are never altered, and the arithmetic wraps inside the stack width.

Top module: `stack_agen`

## Requirements
- R1: Every request carries `req_asize_log` equal to the stack-size code sampled at start, and the stack-pointer arithmetic is done at that width (code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes).
- R2: Every request carries `req_dsize_log` equal to the operand-size code sampled at start (same encoding), and the pointer moves by n = 1 << code bytes per item.
- R3: Op code 0 (single push) issues one store (kind 2) at SP - n with register index 0, and the new pointer is SP - n.
- R4: Op code 1 (single pop) issues one load (kind 1) at SP with register index 0, and the new pointer is SP + n.
- R5: Op code 2 (bulk push) issues two probes (kind 0), at SP - n and then at SP - 8n, then eight stores, register k at SP - (k+1)n for k = 0 to 7 in that order; the new pointer is SP - 8n.
- R6: Op code 3 (bulk pop) issues seven loads at SP + s*n for s = 0, 1, 2, 4, 5, 6, 7 in that order, each with register index 7 - s; slot 3 is skipped; the new pointer is SP + 8n.
- R7: Address and new-pointer arithmetic wraps inside the stack width, and pointer bits above that width are passed through unchanged.
- R8: While `req_valid` is high and `req_ready` is low, the request fields hold steady; the next request appears only after acceptance.
- R9: `sp_valid` is high for exactly one cycle, the cycle after the last request is accepted, with no request pending; `sp_out` keeps its value until the next operation completes.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running operation.
- R11: After reset, `busy`, `req_valid` and `sp_valid` are low and `sp_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 0 push, 1 pop, 2 bulk push, 3 bulk pop |
| sp_in | input | 64 | Stack pointer before the operation |
| opsz_log | input | 2 | Operand size code |
| stksz_log | input | 2 | Stack size code |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_kind | output | 2 | 0 probe, 1 load, 2 store |
| req_addr | output | 64 | Request address |
| req_dsize_log | output | 2 | Data size code |
| req_asize_log | output | 2 | Address size code |
| req_reg | output | 3 | Register index for bulk transfers |
| sp_valid | output | 1 | New stack pointer reported |
| sp_out | output | 64 | New stack pointer |

## Verification
The bench aims at pointers that cross zero inside a 16-bit or 32-bit stack while upper bits are set: a design that did the arithmetic at full width would carry or borrow into the upper bits and report a wrong address and pointer. It mixes operand and stack sizes, so a design that moved the pointer by the stack size, or tagged requests with the operand size as address size, gives wrong addresses or size codes. Bulk pops are checked for the skipped slot and the reversed register order, and bulk pushes for the two probes coming first. Random back-pressure and a second start mid-operation catch requests that drift while stalled and operations that restart.

// File: rtl/stack_agen_pkg.sv
package stack_agen_pkg;

    localparam int SP_W      = 64;
    localparam int BULK_N    = 8;
    localparam int REG_W     = $clog2(BULK_N);
    localparam int SKIP_SLOT = 3;
    localparam int UNIT_W    = $clog2(BULK_N) + 2;
    localparam int STEP_W    = $clog2(BULK_N + 3);

    typedef enum logic [1:0] {
        OP_PUSH     = 2'd0,
        OP_POP      = 2'd1,
        OP_PUSH_ALL = 2'd2,
        OP_POP_ALL  = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        RK_CHECK = 2'd0,
        RK_LOAD  = 2'd1,
        RK_STORE = 2'd2
    } req_kind_e;

    // One request of an operation: kind, offset in operand-size units,
    // register index, and whether it is the final one.
    typedef struct packed {
        req_kind_e                 kind;
        logic signed [UNIT_W-1:0]  units;
        logic [REG_W-1:0]          reg_idx;
        logic                      last;
    } step_t;

    function automatic logic [SP_W-1:0] width_mask(input logic [1:0] lg);
        logic [SP_W-1:0] m;
        m = '0;
        for (int i = 0; i < SP_W; i++)
            if (i < (8 << lg)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [SP_W-1:0] scale_units(
        input logic signed [UNIT_W-1:0] units,
        input logic [1:0]               osz_lg);
        logic [SP_W-1:0] d;
        d = {{(SP_W-UNIT_W){units[UNIT_W-1]}}, units};
        return d << osz_lg;
    endfunction

    function automatic logic [SP_W-1:0] wrap_add(
        input logic [SP_W-1:0] base,
        input logic [SP_W-1:0] delta,
        input logic [1:0]      stk_lg);
        logic [SP_W-1:0] m;
        m = width_mask(stk_lg);
        return (base & ~m) | ((base + delta) & m);
    endfunction

endpackage

// File: rtl/stack_agen_step.sv
module stack_agen_step
    import stack_agen_pkg::*;
(
    input  stk_op_e           op,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);
    logic [STEP_W-1:0] slot;

    always_comb begin
        step = '{kind: RK_LOAD, units: '0, reg_idx: '0, last: 1'b1};
        slot = (idx < STEP_W'(SKIP_SLOT)) ? idx : idx + 1'b1;
        unique case (op)
            OP_PUSH: begin
                step.kind  = RK_STORE;
                step.units = -UNIT_W'(1);
            end
            OP_POP: begin
                step.kind  = RK_LOAD;
                step.units = '0;
            end
            OP_PUSH_ALL: begin
                step.last = (idx == STEP_W'(BULK_N + 1));
                if (idx == '0) begin
                    step.kind  = RK_CHECK;
                    step.units = -UNIT_W'(1);
                end else if (idx == STEP_W'(1)) begin
                    step.kind  = RK_CHECK;
                    step.units = -UNIT_W'(BULK_N);
                end else begin
                    step.kind    = RK_STORE;
                    step.units   = -UNIT_W'(idx - STEP_W'(1));
                    step.reg_idx = REG_W'(idx - STEP_W'(2));
                end
            end
            default: begin
                step.kind    = RK_LOAD;
                step.units   = UNIT_W'(slot);
                step.reg_idx = REG_W'(STEP_W'(BULK_N - 1) - slot);
                step.last    = (idx == STEP_W'(BULK_N - 2));
            end
        endcase
    end
endmodule

// File: rtl/stack_agen_addr.sv
module stack_agen_addr
    import stack_agen_pkg::*;
(
    input  logic [SP_W-1:0]          sp,
    input  logic signed [UNIT_W-1:0] units,
    input  logic [1:0]               osz_lg,
    input  logic [1:0]               stk_lg,
    output logic [SP_W-1:0]          result
);
    always_comb result = wrap_add(sp, scale_units(units, osz_lg), stk_lg);
endmodule

// File: rtl/stack_agen.sv
module stack_agen
    import stack_agen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [SP_W-1:0]      sp_in,
    input  logic [1:0]           opsz_log,
    input  logic [1:0]           stksz_log,
    output logic                 busy,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [1:0]           req_kind,
    output logic [SP_W-1:0]      req_addr,
    output logic [1:0]           req_dsize_log,
    output logic [1:0]           req_asize_log,
    output logic [REG_W-1:0]     req_reg,
    output logic                 sp_valid,
    output logic [SP_W-1:0]      sp_out
);
    logic                  busy_q;
    stk_op_e               op_q;
    logic [SP_W-1:0]       sp_q;
    logic [1:0]            osz_q;
    logic [1:0]            stk_q;
    logic [STEP_W-1:0]     step_q;
    logic                  spv_q;
    logic [SP_W-1:0]       spo_q;

    step_t                 cur;
    logic signed [UNIT_W-1:0] fin_units;
    logic [SP_W-1:0]       fin_sp;
    logic [SP_W-1:0]       cur_addr;

    stack_agen_step u_step (
        .op   (op_q),
        .idx  (step_q),
        .step (cur)
    );

    stack_agen_addr u_req_addr (
        .sp     (sp_q),
        .units  (cur.units),
        .osz_lg (osz_q),
        .stk_lg (stk_q),
        .result (cur_addr)
    );

    always_comb begin
        unique case (op_q)
            OP_PUSH:     fin_units = -UNIT_W'(1);
            OP_POP:      fin_units = UNIT_W'(1);
            OP_PUSH_ALL: fin_units = -UNIT_W'(BULK_N);
            default:     fin_units = UNIT_W'(BULK_N);
        endcase
    end

    stack_agen_addr u_fin_addr (
        .sp     (sp_q),
        .units  (fin_units),
        .osz_lg (osz_q),
        .stk_lg (stk_q),
        .result (fin_sp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_PUSH;
            sp_q   <= '0;
            osz_q  <= '0;
            stk_q  <= '0;
            step_q <= '0;
            spv_q  <= 1'b0;
            spo_q  <= '0;
        end else begin
            spv_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    op_q   <= stk_op_e'(op);
                    sp_q   <= sp_in;
                    osz_q  <= opsz_log;
                    stk_q  <= stksz_log;
                    step_q <= '0;
                end
            end else if (req_ready) begin
                if (cur.last) begin
                    busy_q <= 1'b0;
                    spv_q  <= 1'b1;
                    spo_q  <= fin_sp;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign busy          = busy_q;
    assign req_valid     = busy_q;
    assign req_kind      = cur.kind;
    assign req_addr      = cur_addr;
    assign req_dsize_log = osz_q;
    assign req_asize_log = stk_q;
    assign req_reg       = cur.reg_idx;
    assign sp_valid      = spv_q;
    assign sp_out        = spo_q;
endmodule

// File: rtl/stack_agen_sva.sv
module stack_agen_sva
    import stack_agen_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [1:0]           op,
    input logic [SP_W-1:0]      sp_in,
    input logic [1:0]           opsz_log,
    input logic [1:0]           stksz_log,
    input logic                 busy,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [1:0]           req_kind,
    input logic [SP_W-1:0]      req_addr,
    input logic [1:0]           req_dsize_log,
    input logic [1:0]           req_asize_log,
    input logic [REG_W-1:0]     req_reg,
    input logic                 sp_valid,
    input logic [SP_W-1:0]      sp_out
);
    logic [1:0]      rec_osz;
    logic [1:0]      rec_stk;
    logic [SP_W-1:0] rec_sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_osz <= '0;
            rec_stk <= '0;
            rec_sp  <= '0;
        end else if (start && !busy) begin
            rec_osz <= opsz_log;
            rec_stk <= stksz_log;
            rec_sp  <= sp_in;
        end
    end

    a_r1_asize_follows_stack: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_asize_log == rec_stk);

    a_r2_dsize_follows_operand: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_dsize_log == rec_osz);

    a_r7_upper_bits_kept: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> ((sp_out ^ rec_sp) & ~width_mask(rec_stk)) == '0);

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_kind) && $stable(req_reg)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sp_valid |=> !sp_valid);

    a_r9_nothing_pending: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> !req_valid);

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(req_asize_log) && $stable(req_dsize_log)));
endmodule

bind stack_agen stack_agen_sva u_sva (.*);

// File: tb/stack_agen_tb.sv
module stack_agen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [63:0] sp_in = '0;
    logic [1:0]  opsz_log = 2'd0;
    logic [1:0]  stksz_log = 2'd0;
    logic        busy, req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_kind, req_dsize_log, req_asize_log;
    logic [63:0] req_addr, sp_out;
    logic [2:0]  req_reg;
    logic        sp_valid;

    typedef struct {
        logic [1:0]  kind;
        logic [63:0] addr;
        logic [2:0]  rix;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cur_osz = 0;
    int          cur_ssz = 0;
    bit          ready_always = 1'b1;
    logic [7:0]  lfsr = 8'hA5;
    bit          stall_prev = 1'b0;
    logic [63:0] stall_addr;
    logic [1:0]  stall_kind;
    logic [2:0]  stall_reg;
    int          cycles = 0;

    always #10 clk = ~clk;

    stack_agen u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .sp_in(sp_in),
        .opsz_log(opsz_log), .stksz_log(stksz_log), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_dsize_log(req_dsize_log),
        .req_asize_log(req_asize_log), .req_reg(req_reg),
        .sp_valid(sp_valid), .sp_out(sp_out)
    );

    function automatic logic [63:0] wr(logic [63:0] sp, longint d, int lg);
        logic [63:0] m;
        m = (lg == 3) ? '1 : ((64'd1 << (8 << lg)) - 64'd1);
        return (sp & ~m) | ((sp + 64'(d)) & m);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // monitor: drives ready, compares accepted requests with the scoreboard
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        req_ready = ready_always ? 1'b1 : lfsr[0];
        if (stall_prev && !rst) begin
            chk(req_valid && req_addr == stall_addr && req_kind == stall_kind
                && req_reg == stall_reg, "R8 stalled request held", req_addr, stall_addr);
        end
        stall_prev = req_valid && !req_ready;
        stall_addr = req_addr;
        stall_kind = req_kind;
        stall_reg  = req_reg;
        if (req_valid && req_ready && !rst) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected request", req_addr, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(req_kind == e.kind, {e.tag, " kind"}, 64'(req_kind), 64'(e.kind));
                chk(req_addr == e.addr, {e.tag, " address"}, req_addr, e.addr);
                chk(req_reg == e.rix, {e.tag, " register"}, 64'(req_reg), 64'(e.rix));
                chk(req_dsize_log == 2'(cur_osz), "R2 data size", 64'(req_dsize_log), 64'(cur_osz));
                chk(req_asize_log == 2'(cur_ssz), "R1 address size", 64'(req_asize_log), 64'(cur_ssz));
            end
        end
    end

    task automatic run_op(int o, logic [63:0] sp, int osz, int ssz, bit poke, string tag);
        exp_t e;
        longint n;
        logic [63:0] exp_sp;
        int wait_n;
        n = longint'(1) << osz;
        cur_osz = osz;
        cur_ssz = ssz;
        e.tag = tag;
        case (o)
            0: begin
                e.kind = 2'd2; e.addr = wr(sp, -n, ssz); e.rix = 3'd0; q.push_back(e);
                exp_sp = wr(sp, -n, ssz);
            end
            1: begin
                e.kind = 2'd1; e.addr = sp; e.rix = 3'd0; q.push_back(e);
                exp_sp = wr(sp, n, ssz);
            end
            2: begin
                e.kind = 2'd0; e.rix = 3'd0;
                e.addr = wr(sp, -n, ssz); q.push_back(e);
                e.addr = wr(sp, -8 * n, ssz); q.push_back(e);
                for (int k = 0; k < 8; k++) begin
                    e.kind = 2'd2; e.rix = 3'(k);
                    e.addr = wr(sp, -(k + 1) * n, ssz); q.push_back(e);
                end
                exp_sp = wr(sp, -8 * n, ssz);
            end
            default: begin
                for (int s = 0; s < 8; s++) begin
                    if (s != 3) begin
                        e.kind = 2'd1; e.rix = 3'(7 - s);
                        e.addr = wr(sp, s * n, ssz); q.push_back(e);
                    end
                end
                exp_sp = wr(sp, 8 * n, ssz);
            end
        endcase
        @(negedge clk);
        start = 1'b1; op = 2'(o); sp_in = sp; opsz_log = 2'(osz); stksz_log = 2'(ssz);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; op = 2'd1; sp_in = 64'h1234; opsz_log = 2'd0; stksz_log = 2'd0;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (!sp_valid && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(sp_valid, {tag, " completion"}, 64'(sp_valid), 64'd1);
        chk(sp_out == exp_sp, {tag, " new pointer"}, sp_out, exp_sp);
        chk(q.size() == 0, {tag, " all requests seen"}, 64'(q.size()), 64'd0);
        @(negedge clk);
        chk(!sp_valid, "R9 one-cycle report", 64'(sp_valid), 64'd0);
        chk(sp_out == exp_sp, "R9 pointer held", sp_out, exp_sp);
        chk(!req_valid, "R10 no stray request", 64'(req_valid), 64'd0);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !req_valid && !sp_valid, "R11 idle after reset",
            {61'd0, busy, req_valid, sp_valid}, 64'd0);
        chk(sp_out == '0, "R11 pointer after reset", sp_out, 64'd0);

        run_op(0, 64'h0000_7FFF_FFFF_F000, 3, 3, 0, "R3 push 8B on 64-bit stack");
        run_op(1, 64'hDEAD_BEEF_0000_0100, 2, 2, 0, "R4 pop 4B on 32-bit stack");
        run_op(0, 64'h0000_0000_0000_1000, 1, 3, 0, "R2 push 2B on 64-bit stack");
        run_op(0, 64'hABCD_0000_1234_0002, 2, 1, 0, "R7 push wraps 16-bit stack");
        run_op(1, 64'h5555_0000_FFFF_FFFC, 3, 2, 0, "R7 pop wraps 32-bit stack");
        run_op(0, 64'h0000_0000_0000_0080, 0, 0, 0, "R1 byte stack push");
        ready_always = 1'b0;
        run_op(2, 64'h0000_0000_0000_8000, 2, 3, 0, "R5 bulk push");
        run_op(3, 64'h0000_0000_0000_4000, 1, 2, 0, "R6 bulk pop");
        run_op(2, 64'hFFFF_0000_0000_0008, 1, 1, 0, "R7 bulk push wraps");
        run_op(3, 64'h1111_2222_3333_FFF0, 2, 1, 0, "R7 bulk pop wraps");
        run_op(2, 64'h0000_0001_0000_0100, 3, 3, 1, "R10 bulk push with second start");
        run_op(3, 64'h0000_0000_0000_0200, 3, 2, 1, "R10 bulk pop with second start");
        ready_always = 1'b1;
        run_op(1, 64'h0000_0000_0000_0010, 3, 3, 0, "R4 pop 8B full ready");
        finish_run();
    end
endmodule